// File: doc/BRIEF.md
# I2C Master START Condition Sequencer

This block produces the START condition of an I2C master. Software sets a start-enable command bit. The block then samples the synchronized SDA and SCL lines. Once both lines are high, it times one bit period with a down-counter reloaded from a 7-bit divider value. It then pulls SDA low while SCL is still high, which is the START condition itself. It times one more bit period and finally clears the start-enable bit, leaving SDA held low so that the data phase, which lives elsewhere, can follow.

While the sequence runs, the block refuses new work. Writes to the five command bits are dropped, because commands are never queued. A write to the transmit buffer is rejected and raises a sticky write-collision flag. If another device holds the bus, the block raises a sticky bus-collision flag, releases SDA, stops the counter, clears the start-enable bit and returns to idle. The counter advances only on a phase strobe supplied from outside. The block never drives SCL. All interfaces are plain register-style pins; there is no streaming data path.

Top module: `i2c_start_seq`

## Requirements
- R1: After reset `sda_oe_o`, `ctrl_q_o`, `buf_q_o`, `start_seen_o`, `irq_o`, `bus_coll_o` and `wr_coll_o` are all zero.
- R2: Command bit 0 of `ctrl_q_o` is start-enable. With both lines high and `tick_i` held high, `sda_oe_o` rises exactly `reload_i`+2 clock edges after the edge that set start-enable.
- R3: `start_seen_o` and `irq_o` become 1 on the same edge on which `sda_oe_o` rises.
- R4: Start-enable clears exactly `reload_i`+1 edges after `sda_oe_o` rises, and `sda_oe_o` then stays 1 until reset.
- R5: The baud counter changes only on edges where `tick_i` is 1. With `tick_i` low the sequence stalls with `sda_oe_o`=0 and start-enable still set.
- R6: If start-enable is set while the synchronized lines are both low, `bus_coll_o` is set, start-enable is cleared and `sda_oe_o` stays 0.
- R7: If either synchronized line reads low before SDA is driven, the sequence aborts: `bus_coll_o`=1, start-enable=0, `sda_oe_o`=0 and `start_seen_o`=0.
- R8: If exactly one line is low when start-enable is set, the block waits without raising a flag and starts once both lines read high.
- R9: A `buf_wr_i` on an edge where start-enable is 1 sets `wr_coll_o` and leaves `buf_q_o` unchanged. This includes the edge on which start-enable clears. Otherwise `buf_q_o` takes `buf_wdata_i` on that edge.
- R10: A `ctrl_wr_i` on an edge where start-enable is 1 leaves command bits 4..1 unchanged. When start-enable is 0, the written value is stored.
- R11: `irq_o`, `bus_coll_o` and `wr_coll_o` stay set until cleared by `flag_clr_i` bits 0, 1 and 2 respectively. A set in the same edge wins over a clear.
- R12: Line samples pass through a two-flop synchronizer per line, whose flops reset to 1 (idle bus).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Phase strobe that advances the baud counter |
| sda_i | input | 1 | Raw SDA line level |
| scl_i | input | 1 | Raw SCL line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| reload_i | input | 7 | Baud counter reload value |
| ctrl_wr_i | input | 1 | Command register write strobe |
| ctrl_wdata_i | input | 5 | Command write data, bit 0 = start-enable |
| ctrl_q_o | output | 5 | Command register contents |
| buf_wr_i | input | 1 | Transmit buffer write strobe |
| buf_wdata_i | input | 8 | Transmit buffer write data |
| buf_q_o | output | 8 | Transmit buffer contents |
| start_seen_o | output | 1 | START condition issued |
| irq_o | output | 1 | Sticky interrupt flag |
| bus_coll_o | output | 1 | Sticky bus collision flag |
| wr_coll_o | output | 1 | Sticky write collision flag |
| flag_clr_i | input | 3 | Clear strobes: bit0 irq, bit1 bus collision, bit2 write collision |

## Verification
A buffer write and the hardware clear of start-enable can fall on the same edge. The bench counts edges from the fall of SDA and places a buffer write exactly on the terminal count. That write must be rejected, with `wr_coll_o` set and the buffer unchanged, while start-enable clears on the same edge. A write one cycle later must be accepted. The bench also pulls SCL low partway through the first bit period and judges that the abort beats the counter expiry: SDA is never driven and the start flag stays clear.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HOLD = 2'd2,
    ST_HELD = 2'd3
  } seq_state_t;

  localparam int START_BIT = 0;
  localparam int FLAG_IRQ  = 0;
  localparam int FLAG_BCOL = 1;
  localparam int FLAG_WCOL = 2;
  localparam int FLAG_N    = 3;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] sync_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw_i[g]};
    end
    assign sync_o[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2c_baud_cnt.sv
module i2c_baud_cnt #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [W-1:0] reload_i,
  output logic         expire_o
);
  logic [W-1:0] cnt;

  assign expire_o = run_i && tick_i && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            cnt <= '0;
    else if (load_i)                       cnt <= reload_i;
    else if (run_i && tick_i && cnt != '0) cnt <= cnt - 1'b1;
  end

  // R5: the count only moves on a strobe or a reload
  p_cnt_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load_i) |=> $stable(cnt));
endmodule

// File: rtl/i2c_start_fsm.sv
module i2c_start_fsm
  import i2c_start_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sen_i,
  input  logic sda_s_i,
  input  logic scl_s_i,
  input  logic expire_i,
  output logic load_o,
  output logic run_o,
  output logic sda_oe_o,
  output logic set_start_o,
  output logic set_bcol_o,
  output logic clr_sen_o
);
  seq_state_t state, state_nx;
  logic       sda_oe_nx;

  always_comb begin
    state_nx    = state;
    sda_oe_nx   = sda_oe_o;
    load_o      = 1'b0;
    set_start_o = 1'b0;
    set_bcol_o  = 1'b0;
    clr_sen_o   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (sen_i) begin
          if (sda_s_i && scl_s_i) begin
            load_o   = 1'b1;
            state_nx = ST_WAIT;
          end else if (!sda_s_i && !scl_s_i) begin
            set_bcol_o = 1'b1;
            clr_sen_o  = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (!sda_s_i || !scl_s_i) begin
          set_bcol_o = 1'b1;
          clr_sen_o  = 1'b1;
          sda_oe_nx  = 1'b0;
          state_nx   = ST_IDLE;
        end else if (expire_i) begin
          sda_oe_nx   = 1'b1;
          set_start_o = 1'b1;
          load_o      = 1'b1;
          state_nx    = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (expire_i) begin
          clr_sen_o = 1'b1;
          state_nx  = ST_HELD;
        end
      end
      default: ;
    endcase
  end

  assign run_o = (state == ST_WAIT) || (state == ST_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      state    <= state_nx;
      sda_oe_o <= sda_oe_nx;
    end
  end

  // R7: an abort never leaves SDA driven
  p_abort_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_bcol_o |=> !sda_oe_o && state == ST_IDLE);
  // R4: once held, SDA stays driven
  p_hold_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HELD) |=> sda_oe_o);
endmodule

// File: rtl/i2c_start_regs.sv
module i2c_start_regs
  import i2c_start_pkg::*;
#(
  parameter int CMD_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr_i,
  input  logic [CMD_W-1:0]  ctrl_wdata_i,
  input  logic              buf_wr_i,
  input  logic [DATA_W-1:0] buf_wdata_i,
  input  logic              clr_sen_i,
  input  logic              set_start_i,
  input  logic              set_bcol_i,
  input  logic [FLAG_N-1:0] flag_clr_i,
  output logic [CMD_W-1:0]  ctrl_q_o,
  output logic [DATA_W-1:0] buf_q_o,
  output logic              start_seen_o,
  output logic [FLAG_N-1:0] flags_o
);
  logic              busy;
  logic [FLAG_N-1:0] flag_set;

  assign busy = ctrl_q_o[START_BIT];

  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_IRQ]  = set_start_i;
    flag_set[FLAG_BCOL] = set_bcol_i;
    flag_set[FLAG_WCOL] = buf_wr_i && busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q_o <= '0;
    end else begin
      if (ctrl_wr_i && !busy) ctrl_q_o <= ctrl_wdata_i;
      if (clr_sen_i)          ctrl_q_o[START_BIT] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                buf_q_o <= '0;
    else if (buf_wr_i && !busy) buf_q_o <= buf_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          start_seen_o <= 1'b0;
    else if (set_start_i) start_seen_o <= 1'b1;
    else if (set_bcol_i)  start_seen_o <= 1'b0;
  end

  for (genvar f = 0; f < FLAG_N; f++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             flags_o[f] <= 1'b0;
      else if (flag_set[f])   flags_o[f] <= 1'b1;
      else if (flag_clr_i[f]) flags_o[f] <= 1'b0;
    end
    // R11: flags hold without a clear
    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[f] && !flag_clr_i[f]) |=> flags_o[f]);
  end

  // R9: a rejected buffer write leaves the buffer untouched
  p_wcol_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr_i && busy) |=> $stable(buf_q_o) && flags_o[FLAG_WCOL]);
  // R10: command bits above start-enable are locked while busy
  p_ctrl_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_i && busy) |=> $stable(ctrl_q_o[CMD_W-1:1]));
endmodule

// File: rtl/i2c_start_seq.sv
module i2c_start_seq
  import i2c_start_pkg::*;
#(
  parameter int RELOAD_W    = 7,
  parameter int CMD_W       = 5,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                sda_i,
  input  logic                scl_i,
  output logic                sda_oe_o,
  input  logic [RELOAD_W-1:0] reload_i,
  input  logic                ctrl_wr_i,
  input  logic [CMD_W-1:0]    ctrl_wdata_i,
  output logic [CMD_W-1:0]    ctrl_q_o,
  input  logic                buf_wr_i,
  input  logic [DATA_W-1:0]   buf_wdata_i,
  output logic [DATA_W-1:0]   buf_q_o,
  output logic                start_seen_o,
  output logic                irq_o,
  output logic                bus_coll_o,
  output logic                wr_coll_o,
  input  logic [FLAG_N-1:0]   flag_clr_i
);
  logic [1:0]        lines_s;
  logic              load, run, expire, set_start, set_bcol, clr_sen;
  logic [FLAG_N-1:0] flags;

  i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i({scl_i, sda_i}), .sync_o(lines_s));

  i2c_baud_cnt #(.W(RELOAD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(load), .run_i(run), .tick_i(tick_i),
    .reload_i(reload_i), .expire_o(expire));

  i2c_start_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .sen_i(ctrl_q_o[START_BIT]),
    .sda_s_i(lines_s[0]), .scl_s_i(lines_s[1]), .expire_i(expire),
    .load_o(load), .run_o(run), .sda_oe_o(sda_oe_o),
    .set_start_o(set_start), .set_bcol_o(set_bcol), .clr_sen_o(clr_sen));

  i2c_start_regs #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .ctrl_wr_i(ctrl_wr_i), .ctrl_wdata_i(ctrl_wdata_i),
    .buf_wr_i(buf_wr_i), .buf_wdata_i(buf_wdata_i), .clr_sen_i(clr_sen),
    .set_start_i(set_start), .set_bcol_i(set_bcol), .flag_clr_i(flag_clr_i),
    .ctrl_q_o(ctrl_q_o), .buf_q_o(buf_q_o), .start_seen_o(start_seen_o),
    .flags_o(flags));

  assign irq_o      = flags[FLAG_IRQ];
  assign bus_coll_o = flags[FLAG_BCOL];
  assign wr_coll_o  = flags[FLAG_WCOL];

  // R3: SDA is only pulled with the start flags raised
  p_sda_with_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> start_seen_o && irq_o);
  // R6: a new collision always drops start-enable
  p_coll_drops_sen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_coll_o) |-> !ctrl_q_o[START_BIT] && !sda_oe_o);
endmodule

// File: tb/i2c_start_seq_tb_top.sv
module i2c_start_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       sda_ext = 1'b1, scl_ext = 1'b1;
  logic       sda_oe;
  logic [6:0] reload = 7'd3;
  logic       ctrl_wr = 1'b0;
  logic [4:0] ctrl_wdata = '0;
  logic [4:0] ctrl_q;
  logic       buf_wr = 1'b0;
  logic [7:0] buf_wdata = '0;
  logic [7:0] buf_q;
  logic       start_seen, irq, bus_coll, wr_coll;
  logic [2:0] flag_clr = '0;
  logic       sda_line;
  int         n_run = 0, n_fail = 0;

  assign sda_line = sda_ext & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_start_seq dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .sda_i(sda_line), .scl_i(scl_ext),
    .sda_oe_o(sda_oe), .reload_i(reload), .ctrl_wr_i(ctrl_wr),
    .ctrl_wdata_i(ctrl_wdata), .ctrl_q_o(ctrl_q), .buf_wr_i(buf_wr),
    .buf_wdata_i(buf_wdata), .buf_q_o(buf_q), .start_seen_o(start_seen),
    .irq_o(irq), .bus_coll_o(bus_coll), .wr_coll_o(wr_coll), .flag_clr_i(flag_clr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick = 1'b1; sda_ext = 1'b1; scl_ext = 1'b1;
    ctrl_wr = 1'b0; buf_wr = 1'b0; flag_clr = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic wr_ctrl(input logic [4:0] v);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
    @(posedge clk); #1 ctrl_wr = 1'b0;
  endtask

  task automatic wr_buf(input logic [7:0] v);
    @(negedge clk); buf_wr = 1'b1; buf_wdata = v;
    @(posedge clk); #1 buf_wr = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk(sda_oe == 0 && ctrl_q == 0 && buf_q == 0, "R1 outputs", {sda_oe, ctrl_q, buf_q}, 0);
    chk({start_seen, irq, bus_coll, wr_coll} == 0, "R1 flags", {start_seen, irq, bus_coll, wr_coll}, 0);
  endtask

  task automatic t_timing(input int r);
    int n, m;
    do_reset();
    reload = 7'(r);
    wr_ctrl(5'b00001);
    n = 0;
    while (!sda_oe && n < 600) begin @(posedge clk); #1; n++; end
    chk(n == r + 2, "R2 enable to SDA low", n, r + 2);
    chk(start_seen && irq, "R3 flags at SDA fall", {start_seen, irq}, 3);
    m = 0;
    while (ctrl_q[0] && m < 600) begin @(posedge clk); #1; m++; end
    chk(m == r + 1, "R4 SDA low to enable clear", m, r + 1);
    repeat (5) @(posedge clk);
    #1 chk(sda_oe == 1, "R4 SDA held", sda_oe, 1);
  endtask

  task automatic t_frozen();
    do_reset();
    reload = 7'd2; tick = 1'b0;
    wr_ctrl(5'b00001);
    repeat (30) @(posedge clk);
    #1 chk(sda_oe == 0 && ctrl_q[0] == 1, "R5 stall without strobe", {sda_oe, ctrl_q[0]}, 1);
    tick = 1'b1;
    repeat (4) @(posedge clk);
    #1 chk(sda_oe == 1, "R5 resumes on strobe", sda_oe, 1);
  endtask

  task automatic t_coll_idle();
    do_reset();
    sda_ext = 1'b0; scl_ext = 1'b0;
    repeat (4) @(posedge clk);
    wr_ctrl(5'b00001);
    repeat (2) @(posedge clk);
    #1 chk(bus_coll == 1 && ctrl_q[0] == 0 && sda_oe == 0, "R6 both low at start",
           {bus_coll, ctrl_q[0], sda_oe}, 4);
  endtask

  task automatic t_coll_run();
    do_reset();
    reload = 7'd10;
    wr_ctrl(5'b00001);
    repeat (3) @(posedge clk);
    #1 scl_ext = 1'b0;
    repeat (5) @(posedge clk);
    #1 chk(bus_coll == 1 && ctrl_q[0] == 0, "R7 SCL low aborts", {bus_coll, ctrl_q[0]}, 2);
    chk(sda_oe == 0 && start_seen == 0, "R7 no START issued", {sda_oe, start_seen}, 0);
    scl_ext = 1'b1;
    repeat (20) @(posedge clk);
    #1 chk(sda_oe == 0, "R7 stays idle", sda_oe, 0);
  endtask

  task automatic t_one_low();
    do_reset();
    reload = 7'd1; scl_ext = 1'b0;
    repeat (4) @(posedge clk);
    wr_ctrl(5'b00001);
    repeat (15) @(posedge clk);
    #1 chk(bus_coll == 0 && sda_oe == 0 && ctrl_q[0] == 1, "R8 waits on one low line",
           {bus_coll, sda_oe, ctrl_q[0]}, 1);
    scl_ext = 1'b1;
    repeat (8) @(posedge clk);
    #1 chk(sda_oe == 1 && bus_coll == 0, "R8 starts after release", {sda_oe, bus_coll}, 2);
  endtask

  task automatic t_wcol_edge();
    int r;
    r = 4;
    do_reset();
    reload = 7'(r);
    wr_ctrl(5'b00001);
    while (!sda_oe) begin @(posedge clk); #1; end
    repeat (r) @(posedge clk);
    wr_buf(8'h55);
    chk(wr_coll == 1 && buf_q == 8'h00, "R9 write on final edge rejected", {wr_coll, buf_q}, 256);
    chk(ctrl_q[0] == 0, "R4 enable cleared on same edge", ctrl_q[0], 0);
    wr_buf(8'hAA);
    chk(buf_q == 8'hAA, "R9 write accepted after clear", buf_q, 8'hAA);
  endtask

  task automatic t_lockout();
    do_reset();
    reload = 7'd6;
    wr_ctrl(5'b00001);
    wr_ctrl(5'b11110);
    chk(ctrl_q == 5'b00001, "R10 write ignored while busy", ctrl_q, 1);
    while (ctrl_q[0]) begin @(posedge clk); #1; end
    wr_ctrl(5'b00100);
    chk(ctrl_q == 5'b00100, "R10 write taken when idle", ctrl_q, 4);
  endtask

  task automatic t_clear();
    do_reset();
    sda_ext = 1'b0; scl_ext = 1'b0;
    repeat (4) @(posedge clk);
    wr_ctrl(5'b00001);
    repeat (10) @(posedge clk);
    #1 chk(bus_coll == 1, "R11 flag sticky", bus_coll, 1);
    @(negedge clk); flag_clr = 3'b010;
    @(posedge clk); #1 flag_clr = '0;
    chk(bus_coll == 0, "R11 flag cleared", bus_coll, 0);
  endtask

  task automatic t_sync();
    do_reset();
    reload = 7'd20;
    wr_ctrl(5'b00001);
    repeat (3) @(posedge clk);
    @(negedge clk) scl_ext = 1'b0;
    @(negedge clk) scl_ext = 1'b1;
    @(posedge clk); #1;
    chk(bus_coll == 0, "R12 two-stage delay", bus_coll, 0);
    @(posedge clk); #1;
    chk(bus_coll == 1, "R12 glitch seen after sync", bus_coll, 1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_timing(3);
        t_timing(0);
        t_timing(10);
        t_frozen();
        t_coll_idle();
        t_coll_run();
        t_one_low();
        t_wcol_edge();
        t_lockout();
        t_clear();
        t_sync();
      end
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule